// File: doc/BRIEF.md
# Reverse-Channel Run-Length Expander

This block sits on the receive side of a byte-wide parallel link that is running in the reverse direction, from peripheral to host. Each incoming byte arrives with a type level. When the level is high the byte is data. When it is low the byte is a command. A command whose top bit is clear carries a run-length count in its low seven bits. The block absorbs that command, keeps the count, and then presents the next data byte on its output count + 1 times, so one run gives from 1 to 128 copies. A data byte that has no count ahead of it goes out exactly once. Commands never reach the output.

A command whose top bit is set would be a channel address. Such addresses are not supported in this direction, so the byte is discarded and a one-cycle error flag is raised. Input and output both use valid/ready handshakes. The output side feeds a receive FIFO and may stall for any number of cycles. While copies are still pending, the input is held off. The one exception is the cycle in which the final copy is taken. In that cycle the next byte may be accepted, so a stream without runs can move one byte per cycle.

The controller is a three-state machine:
- `ST_IDLE`: no count is held.
- `ST_ARMED`: a count is held.
- `ST_REPEAT`: the output register is presenting copies.

Its transitions are:
- IDLE→ARMED when a count command is accepted.
- IDLE→REPEAT when a data byte is accepted.
- ARMED→ARMED when another count replaces the held one, or when an address command is dropped.
- ARMED→REPEAT when a data byte is accepted and the held count is transferred to the repeat counter.
- REPEAT→REPEAT while copies remain, or when the final copy is taken and a data byte is accepted in the same cycle.
- REPEAT→ARMED when the final copy is taken and a count arrives in the same cycle.
- REPEAT→IDLE when the final copy is taken and no count or data arrives.

Top module: `ecp_rle_expander`

## Requirements
- R1: After reset `out_valid` and `cmd_err` are 0, `in_ready` is 1, and no count is held.
- R2: A byte accepted with `in_is_data`=1 while no count is held appears on the output exactly once.
- R3: A byte accepted with `in_is_data`=0 and bit 7 = 0 sets count N = bits 6:0. The next data byte then appears N+1 times in a row: N=0 gives 1 copy and N=127 gives 128 copies.
- R4: No command byte (`in_is_data`=0) ever appears on the output.
- R5: A byte accepted with `in_is_data`=0 and bit 7 = 1 is dropped. `cmd_err` is 1 in the cycle after acceptance, and a held count is left unchanged.
- R6: A count that arrives while another count is held, with no data byte between them, replaces the held count.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. While copies of a byte remain after the current one, no input is accepted.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` is unchanged in the next cycle.
- R9: The held count is cleared once its byte has been fully emitted, so a later data byte with no new count is emitted once.
- R10: A byte accepted in the same cycle as the final copy is taken is processed normally, with nothing lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming byte present |
| in_data | input | 8 | Incoming byte |
| in_is_data | input | 1 | Type level: 1 = data, 0 = command |
| in_ready | output | 1 | Block accepts the incoming byte this cycle |
| out_valid | output | 1 | Expanded byte present |
| out_data | output | 8 | Expanded byte |
| out_ready | input | 1 | Receive FIFO takes the byte this cycle |
| cmd_err | output | 1 | One-cycle pulse after an unsupported address command is dropped |

## Verification
The case to watch is the coincidence of the final-copy handshake and the acceptance of a new byte. In that cycle the repeat counter must retire one byte and load the next, or the count register must load while the FSM leaves `ST_REPEAT`. The coincidence is provoked by holding `out_ready` high while the driver streams bytes back to back. It is judged by the scoreboard, which sees every expected copy in order with none missing and none extra, and by a port-level counter that must record at least one such overlap. A second phase with a pseudo-random `out_ready` exercises the stall rules.

// File: rtl/ecp_rle_pkg.sv
package ecp_rle_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_REPEAT = 2'd2
    } rle_state_t;
endpackage

// File: rtl/ecp_rle_classify.sv
module ecp_rle_classify #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic              is_data_i,
    output logic              kind_data_o,
    output logic              kind_count_o,
    output logic              kind_bad_o,
    output logic [DATA_W-2:0] count_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        kind_data_o  = is_data_i;
        kind_count_o = !is_data_i && !byte_i[MSB];
        kind_bad_o   = !is_data_i &&  byte_i[MSB];
        count_o      = byte_i[MSB-1:0];
    end
endmodule

// File: rtl/ecp_rle_repeat.sv
module ecp_rle_repeat #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_byte_i,
    input  logic [CNT_W-1:0]  load_cnt_i,
    input  logic              step_i,
    output logic              busy_o,
    output logic              last_o,
    output logic [DATA_W-1:0] byte_o
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            remain_q <= '0;
            byte_o   <= '0;
        end else if (load_i) begin
            busy_o   <= 1'b1;
            remain_q <= load_cnt_i;
            byte_o   <= load_byte_i;
        end else if (step_i && busy_o) begin
            if (remain_q == '0) begin
                busy_o <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign last_o = busy_o && (remain_q == '0);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !step_i) |=> (busy_o && $stable(byte_o))); // R8
    AST_COPIES_REMAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_i && !last_o) |=> busy_o); // R3
endmodule

// File: rtl/ecp_rle_expander.sv
module ecp_rle_expander
    import ecp_rle_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              cmd_err
);
    localparam int CNT_W = DATA_W - 1;

    rle_state_t       state_q, state_d;
    logic [CNT_W-1:0] held_q;
    logic             kind_data, kind_count, kind_bad;
    logic [CNT_W-1:0] cmd_count;
    logic             acc, fin, rpt_last, rpt_busy, rpt_load;
    logic [CNT_W-1:0] rpt_cnt;

    ecp_rle_classify #(.DATA_W(DATA_W)) u_cls (
        .byte_i       (in_data),
        .is_data_i    (in_is_data),
        .kind_data_o  (kind_data),
        .kind_count_o (kind_count),
        .kind_bad_o   (kind_bad),
        .count_o      (cmd_count)
    );

    ecp_rle_repeat #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rpt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (rpt_load),
        .load_byte_i (in_data),
        .load_cnt_i  (rpt_cnt),
        .step_i      (out_ready),
        .busy_o      (rpt_busy),
        .last_o      (rpt_last),
        .byte_o      (out_data)
    );

    // Output / handshake process
    always_comb begin
        fin       = rpt_last && out_ready;
        in_ready  = (state_q != ST_REPEAT) || fin;
        acc       = in_valid && in_ready;
        rpt_load  = acc && kind_data;
        rpt_cnt   = (state_q == ST_ARMED) ? held_q : '0;
        out_valid = rpt_busy;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && kind_data)       state_d = ST_REPEAT;
                else if (acc && kind_count) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (acc && kind_data)       state_d = ST_REPEAT;
            end
            ST_REPEAT: begin
                if (fin) begin
                    if (acc && kind_data)       state_d = ST_REPEAT;
                    else if (acc && kind_count) state_d = ST_ARMED;
                    else                        state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
            cmd_err <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_err <= acc && kind_bad;
            if (acc && kind_count)     held_q <= cmd_count;
            else if (acc && kind_data) held_q <= '0;
        end
    end

    AST_BAD_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind_bad) |=> cmd_err); // R5
    AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R7
    AST_STATE_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPEAT) == rpt_busy); // R7
    AST_CMD_SWALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !kind_data && !out_valid) |=> !out_valid); // R4
    AST_PLAIN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && acc && kind_data) |=> (out_valid && rpt_last)); // R2
    AST_COUNT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind_count) |=> (state_q == ST_ARMED)); // R6
    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !(acc && kind_data)) |=> !out_valid); // R9
endmodule

// File: tb/sim_ecp_rle_expander.sv
module sim_ecp_rle_expander;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_is_data = 1'b1;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       cmd_err;

    int   checks = 0;
    int   errors = 0;
    int   err_exp = 0;
    int   err_seen = 0;
    int   overlap = 0;
    bit   rand_ready = 1'b0;
    bit   done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  q[$];
    bit          held_v = 1'b0;
    int          held_n = 0;
    bit          prev_stall = 1'b0;
    logic [7:0]  prev_data = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    ecp_rle_expander u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_is_data(in_is_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .cmd_err(cmd_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = rand_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Monitor: samples a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n) begin
            if (cmd_err) err_seen++;
            if (prev_stall) begin
                chk(out_valid === 1'b1 && out_data === prev_data, "R8", out_data, prev_data);
            end
            if (out_valid && !out_ready) begin
                chk(in_ready === 1'b0, "R7", in_ready, 0);
            end
            if (out_valid && out_ready && in_valid && in_ready) overlap++;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4 extra output", out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = q.pop_front();
                    chk(out_data === e, "R3 scoreboard", out_data, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    // Driver: pushes expected bytes at acceptance
    task automatic send(input bit is_d, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_is_data = is_d; in_data = b;
        forever begin
            #(CLK_P/4);
            if (in_ready) break;
            @(negedge clk);
        end
        if (is_d) begin
            int n;
            n = held_v ? held_n + 1 : 1;
            for (int i = 0; i < n; i++) q.push_back(b);
            held_v = 1'b0;
        end else if (b[7]) begin
            err_exp++;
        end else begin
            held_v = 1'b1; held_n = b[6:0];
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (q.size() == 0 && !out_valid) break;
        end
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R3 all copies emitted", q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_P/4);
        chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
        chk(cmd_err === 1'b0, "R1 cmd_err", cmd_err, 0);

        // Continuous out_ready: back-to-back stream, overlaps (R10)
        send(1, 8'hA5); send(1, 8'h3C);            // R2
        send(0, 8'h03); send(1, 8'h77);            // R3: 4 copies
        send(0, 8'h00); send(1, 8'h11);            // R3: 1 copy
        send(0, 8'h05); send(0, 8'h01); send(1, 8'h42); // R6: 2 copies
        send(0, 8'h02); send(0, 8'h85); send(1, 8'h99); // R5: count kept, 3 copies
        send(1, 8'h55);                             // R9: once
        send(0, 8'h7F); send(1, 8'hEE);            // R3: 128 copies
        send(1, 8'h12); send(0, 8'h01); send(1, 8'h34);
        drain();
        chk(overlap > 0, "R10 overlap seen", overlap, 1);

        // Pseudo-random stalls
        rand_ready = 1'b1;
        send(0, 8'h06); send(1, 8'hC3);
        send(0, 8'hFF); send(1, 8'h21);            // R5 with no count held
        send(1, 8'h21);
        for (int k = 0; k < 60; k++) begin
            logic [7:0] r;
            r = lfsr[7:0] ^ 8'(k * 37);
            if (r[1:0] == 2'b00) send(0, {1'b0, 3'b000, r[6:3]});
            else if (r[4:0] == 5'b11101) send(0, 8'h80 | r);
            else send(1, r);
        end
        drain();
        chk(err_seen == err_exp, "R5 cmd_err pulses", err_seen, err_exp);
        finish_run();
    end
endmodule